// File: doc/BRIEF.md
# Packet Command Decoder with Sense Tracking

This block sits behind the task-file controller of an optical-drive style storage interface. When the host has written a 12-byte command packet, the controller strobes the packet into the decoder. The decoder classifies the opcode and runs the rule checks: the rejection after reset, whether media is present, whether fields are in range, and what the media side reports. It then issues one response descriptor. The descriptor holds a completion status, the number of bytes to return, which buffer the bytes come from, and, for sector reads, the start address, block count and read mode, together with a one-cycle start-read request.

Every completion that records a 16-bit result code also updates the sense bytes, which the host later fetches through a byte-wide read port, and the error register. The low byte of the result is the sense key. Its low nibble feeds the upper half of the error register. A response stays up until the controller acknowledges it. Any packet that arrives while a response is pending is dropped without effect. Packet byte i sits at `pkt_data[8*i+7:8*i]`, so byte 0, the opcode, sits in the least significant bits.

Top module: `pkt_cmd_decoder`

## Requirements
- R1: After reset, `resp_valid`, `rd_start`, `err_reg`, `resp_status` and all sense bytes read as zero.
- R2: A strobe seen while no response is pending yields exactly one response on the next cycle. The response holds steady until `resp_ack`. A strobe seen while a response is pending changes no output and no sense byte, and it produces no later response.
- R3: While the was-reset flag is set (it is set by reset), any packet whose opcode is not 0x13 completes with result 0x2906 and is not executed, and this clears the flag. A 0x13 packet leaves the flag set.
- R4: Recording a result R writes sense byte 0 = 0xF0, byte 2 = R[7:0] and byte 8 = R[15:8], and sets `err_reg` = {R[3:0], 4'h0}. A non-zero R gives status 0x51, length 0 and source 0.
- R5: Opcodes 0x00, 0x20 and 0x70 record result 0 and give status 0x50, length 0 and source 0.
- R6: Identify (0x11) takes its offset from byte 2 and its length from byte 4. An offset of 32 or more records 0x2405. Otherwise the response has source 1, status 0x58, `resp_offset` = offset and length min(len, 32 - offset), and result 0 is recorded.
- R7: Table-of-contents read (0x14) takes its length from bytes 3 (high) and 4 (low), clipped to 408. A non-zero `media_code` is recorded as the result. Otherwise the response has source 3 and status 0x58, and result 0 is recorded.
- R8: Sector read (0x30) takes the LBA from bytes 2..4 and the count from bytes 8..10 (both most significant byte first) and the mode from byte 1. A non-zero `media_code` is recorded and sense bytes 5..7 receive the LBA, MSB first. A count of 0 records 0 with status 0x50. Otherwise `rd_start` pulses for one cycle with the response, which has source 4, length 2048 and status 0x58, and result 0 is recorded.
- R9: Request-sense (0x13) gives source 2, status 0x58 and length min(byte 4, 10). It leaves the sense bytes and `err_reg` unchanged.
- R10: With `disc_present` low, opcodes 0x14 and 0x30 record 0x3A02 and never pulse `rd_start`.
- R11: Any other opcode records 0x2005.
- R12: `sense_byte` shows sense byte `sense_idx`, and shows 0 for an index of 10 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet strobe, one cycle |
| pkt_data | input | 96 | Packet bytes, byte 0 in bits 7:0 |
| disc_present | input | 1 | Media present |
| media_code | input | 16 | Result from the media side, 0 = success |
| resp_ack | input | 1 | Controller has consumed the response |
| sense_idx | input | 4 | Sense byte select |
| resp_valid | output | 1 | Response pending |
| resp_status | output | 8 | Completion status |
| resp_src | output | 3 | Buffer source: 0 none, 1 identify, 2 sense, 3 TOC, 4 sector |
| resp_offset | output | 8 | Start offset into the source buffer |
| resp_len | output | 16 | Bytes to return |
| rd_start | output | 1 | Start-read request pulse |
| rd_lba | output | 24 | Sector read start address |
| rd_count | output | 24 | Sector read block count |
| rd_mode | output | 8 | Sector read mode |
| err_reg | output | 8 | Error register |
| sense_byte | output | 8 | Selected sense byte |

## Verification
The in-line assertions guard behaviour that holds on every cycle. A pending response holds steady until it is acknowledged. A response only ever follows a strobe. The start-read pulse lasts one cycle and appears only with a sector response. A failed completion never carries data. The was-reset flag, once cleared, stays cleared. Only the bench scenarios can show the values themselves. These are the clipped lengths, the exact result codes and their effect on the sense bytes and the error register, the priority of the reset rejection over the no-disc check, and the fact that a request-sense leaves earlier sense data intact.

// File: rtl/pcd_pkg.sv
`timescale 1ns/1ps
package pcd_pkg;

  localparam logic [7:0] OP_TEST_READY = 8'h00;
  localparam logic [7:0] OP_IDENTIFY   = 8'h11;
  localparam logic [7:0] OP_REQ_SENSE  = 8'h13;
  localparam logic [7:0] OP_READ_TOC   = 8'h14;
  localparam logic [7:0] OP_PLAY       = 8'h20;
  localparam logic [7:0] OP_READ_SECT  = 8'h30;
  localparam logic [7:0] OP_SPIN_UP    = 8'h70;

  // result codes: low byte is the sense key, high byte the qualifier
  localparam logic [15:0] RES_OK       = 16'h0000;
  localparam logic [15:0] RES_RESET    = 16'h2906;
  localparam logic [15:0] RES_BADFIELD = 16'h2405;
  localparam logic [15:0] RES_BADCMD   = 16'h2005;
  localparam logic [15:0] RES_NODISC   = 16'h3A02;

  localparam logic [7:0] ST_DONE = 8'h50;
  localparam logic [7:0] ST_FAIL = 8'h51;
  localparam logic [7:0] ST_DATA = 8'h58;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_IDENT  = 3'd1,
    SRC_SENSE  = 3'd2,
    SRC_TOC    = 3'd3,
    SRC_SECTOR = 3'd4
  } src_e;

  typedef struct packed {
    logic [7:0]  status;
    logic [15:0] len;
    src_e        src;
    logic [7:0]  ofs;
    logic        set_res;
    logic [15:0] result;
    logic        lba_wr;
    logic        start;
    logic        clr_reset;
    logic [23:0] lba;
    logic [23:0] count;
    logic [7:0]  mode;
  } resp_t;

  function automatic logic [15:0] clip_len(logic [15:0] req, logic [15:0] avail);
    return (req > avail) ? avail : req;
  endfunction

  function automatic logic [7:0] err_from_result(logic [15:0] res);
    return {res[3:0], 4'h0};
  endfunction

  function automatic resp_t mk_fail(logic [15:0] code);
    resp_t r;
    r = '0;
    r.status  = ST_FAIL;
    r.set_res = 1'b1;
    r.result  = code;
    r.src     = SRC_NONE;
    return r;
  endfunction

  function automatic resp_t mk_done();
    resp_t r;
    r = '0;
    r.status  = ST_DONE;
    r.set_res = 1'b1;
    r.result  = RES_OK;
    r.src     = SRC_NONE;
    return r;
  endfunction

  function automatic resp_t mk_data(src_e s, logic [15:0] n, logic [7:0] o, logic rec);
    resp_t r;
    r = '0;
    r.status  = ST_DATA;
    r.src     = s;
    r.len     = n;
    r.ofs     = o;
    r.set_res = rec;
    r.result  = RES_OK;
    return r;
  endfunction

endpackage

// File: rtl/pcd_decode.sv
`timescale 1ns/1ps
module pcd_decode
  import pcd_pkg::*;
#(
  parameter int IDENT_BYTES  = 32,
  parameter int TOC_BYTES    = 408,
  parameter int SENSE_BYTES  = 10,
  parameter int SECTOR_BYTES = 2048,
  parameter int PKT_BYTES    = 12
) (
  input  logic [PKT_BYTES*8-1:0] pkt,
  input  logic                   was_reset,
  input  logic                   disc_present,
  input  logic [15:0]            media_code,
  output resp_t                  rsp
);

  localparam logic [15:0] IDENT_LIM  = 16'(IDENT_BYTES);
  localparam logic [15:0] TOC_LIM    = 16'(TOC_BYTES);
  localparam logic [15:0] SENSE_LIM  = 16'(SENSE_BYTES);
  localparam logic [15:0] SECTOR_LEN = 16'(SECTOR_BYTES);

  logic [7:0] b [PKT_BYTES];

  for (genvar i = 0; i < PKT_BYTES; i++) begin : g_bytes
    assign b[i] = pkt[8*i +: 8];
  end

  logic [7:0]  op;
  logic [23:0] sect_lba;
  logic [23:0] sect_cnt;
  logic [15:0] ident_ofs;
  logic        ident_bad;

  assign op        = b[0];
  assign sect_lba  = {b[2], b[3], b[4]};
  assign sect_cnt  = {b[8], b[9], b[10]};
  assign ident_ofs = {8'h00, b[2]};
  assign ident_bad = (ident_ofs >= IDENT_LIM);

  always_comb begin
    rsp = '0;
    if (was_reset && op != OP_REQ_SENSE) begin
      rsp = mk_fail(RES_RESET);
      rsp.clr_reset = 1'b1;
    end else begin
      unique case (op)
        OP_TEST_READY, OP_PLAY, OP_SPIN_UP: rsp = mk_done();
        OP_IDENTIFY: begin
          if (ident_bad) rsp = mk_fail(RES_BADFIELD);
          else rsp = mk_data(SRC_IDENT,
                             clip_len({8'h00, b[4]}, IDENT_LIM - ident_ofs),
                             b[2], 1'b1);
        end
        OP_REQ_SENSE: rsp = mk_data(SRC_SENSE, clip_len({8'h00, b[4]}, SENSE_LIM),
                                    8'h00, 1'b0);
        OP_READ_TOC: begin
          if (!disc_present)        rsp = mk_fail(RES_NODISC);
          else if (media_code != 0) rsp = mk_fail(media_code);
          else rsp = mk_data(SRC_TOC, clip_len({b[3], b[4]}, TOC_LIM), 8'h00, 1'b1);
        end
        OP_READ_SECT: begin
          if (!disc_present) begin
            rsp = mk_fail(RES_NODISC);
          end else begin
            if (media_code != 0) begin
              rsp = mk_fail(media_code);
              rsp.lba_wr = 1'b1;
            end else if (sect_cnt == 24'd0) begin
              rsp = mk_done();
            end else begin
              rsp = mk_data(SRC_SECTOR, SECTOR_LEN, 8'h00, 1'b1);
              rsp.start = 1'b1;
            end
            rsp.lba   = sect_lba;
            rsp.count = sect_cnt;
            rsp.mode  = b[1];
          end
        end
        default: rsp = mk_fail(RES_BADCMD);
      endcase
    end
  end

endmodule

// File: rtl/pcd_sense.sv
`timescale 1ns/1ps
module pcd_sense
  import pcd_pkg::*;
#(
  parameter int SENSE_BYTES = 10,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [15:0]      result,
  input  logic             lba_wr,
  input  logic [23:0]      lba,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       rd_byte,
  output logic [7:0]       err
);

  logic [7:0] sq [SENSE_BYTES];

  for (genvar i = 0; i < SENSE_BYTES; i++) begin : g_sb
    logic [7:0] nxt;
    always_comb begin
      nxt = sq[i];
      case (i)
        0:       nxt = 8'hF0;
        2:       nxt = result[7:0];
        8:       nxt = result[15:8];
        5:       if (lba_wr) nxt = lba[23:16];
        6:       if (lba_wr) nxt = lba[15:8];
        7:       if (lba_wr) nxt = lba[7:0];
        default: nxt = sq[i];
      endcase
    end
    always_ff @(posedge clk) begin
      if (!rst_n)   sq[i] <= 8'h00;
      else if (upd) sq[i] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   err <= 8'h00;
    else if (upd) err <= err_from_result(result);
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int k = 0; k < SENSE_BYTES; k++)
      if (int'(idx) == k) rd_byte = sq[k];
  end

  // R4: a recorded result always leaves the fixed header tag in byte 0
  a_r4_tag: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> sq[0] == 8'hF0);

  // R4: the error register never changes without a recorded result
  a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(err));

endmodule

// File: rtl/pkt_cmd_decoder.sv
`timescale 1ns/1ps
module pkt_cmd_decoder
  import pcd_pkg::*;
#(
  parameter int PKT_BYTES    = 12,
  parameter int IDENT_BYTES  = 32,
  parameter int TOC_BYTES    = 408,
  parameter int SENSE_BYTES  = 10,
  parameter int SECTOR_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pkt_valid,
  input  logic [95:0] pkt_data,
  input  logic        disc_present,
  input  logic [15:0] media_code,
  input  logic        resp_ack,
  input  logic [3:0]  sense_idx,
  output logic        resp_valid,
  output logic [7:0]  resp_status,
  output logic [2:0]  resp_src,
  output logic [7:0]  resp_offset,
  output logic [15:0] resp_len,
  output logic        rd_start,
  output logic [23:0] rd_lba,
  output logic [23:0] rd_count,
  output logic [7:0]  rd_mode,
  output logic [7:0]  err_reg,
  output logic [7:0]  sense_byte
);

  localparam int IDX_W = 4;

  resp_t rsp_d, rsp_q;
  logic  was_reset_q;
  logic  accept;
  logic  start_q;
  logic  sense_upd;

  assign accept    = pkt_valid && !resp_valid;
  assign sense_upd = accept && rsp_d.set_res;

  pcd_decode #(
    .IDENT_BYTES (IDENT_BYTES),
    .TOC_BYTES   (TOC_BYTES),
    .SENSE_BYTES (SENSE_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES),
    .PKT_BYTES   (PKT_BYTES)
  ) u_dec (
    .pkt         (pkt_data[PKT_BYTES*8-1:0]),
    .was_reset   (was_reset_q),
    .disc_present(disc_present),
    .media_code  (media_code),
    .rsp         (rsp_d)
  );

  pcd_sense #(
    .SENSE_BYTES(SENSE_BYTES),
    .IDX_W      (IDX_W)
  ) u_sense (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (sense_upd),
    .result (rsp_d.result),
    .lba_wr (rsp_d.lba_wr),
    .lba    (rsp_d.lba),
    .idx    (sense_idx),
    .rd_byte(sense_byte),
    .err    (err_reg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q       <= '0;
      resp_valid  <= 1'b0;
      start_q     <= 1'b0;
      was_reset_q <= 1'b1;
    end else if (accept) begin
      rsp_q      <= rsp_d;
      resp_valid <= 1'b1;
      start_q    <= rsp_d.start;
      if (rsp_d.clr_reset) was_reset_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (resp_ack) resp_valid <= 1'b0;
    end
  end

  assign resp_status = rsp_q.status;
  assign resp_src    = 3'(rsp_q.src);
  assign resp_offset = rsp_q.ofs;
  assign resp_len    = rsp_q.len;
  assign rd_start    = start_q;
  assign rd_lba      = rsp_q.lba;
  assign rd_count    = rsp_q.count;
  assign rd_mode     = rsp_q.mode;

  // R2: a pending response is frozen until acknowledged
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ack |=> resp_valid && $stable(resp_status)
      && $stable(resp_len) && $stable(resp_src));

  // R2: a response only ever follows a strobe
  a_r2_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(pkt_valid));

  // R8: start-read is a single-cycle pulse tied to a sector response
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> resp_valid && resp_src == 3'd4);
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);

  // R4: a failed completion carries no data
  a_r4_nodata: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_status == ST_FAIL |-> resp_len == 16'd0 && resp_src == 3'd0);

  // R3: once cleared, the was-reset flag stays cleared
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !was_reset_q |=> !was_reset_q);

endmodule

// File: tb/sim_pkt_cmd_decoder.sv
`timescale 1ns/1ps
module sim_pkt_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_valid;
  logic [95:0] pkt_data;
  logic        disc_present;
  logic [15:0] media_code;
  logic        resp_ack;
  logic [3:0]  sense_idx;
  logic        resp_valid;
  logic [7:0]  resp_status;
  logic [2:0]  resp_src;
  logic [7:0]  resp_offset;
  logic [15:0] resp_len;
  logic        rd_start;
  logic [23:0] rd_lba;
  logic [23:0] rd_count;
  logic [7:0]  rd_mode;
  logic [7:0]  err_reg;
  logic [7:0]  sense_byte;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the host-visible state
  bit       m_was_reset;
  bit [7:0] m_sense [10];
  bit [7:0] m_err;

  always #2.5 clk = ~clk;

  pkt_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .disc_present(disc_present), .media_code(media_code), .resp_ack(resp_ack),
    .sense_idx(sense_idx), .resp_valid(resp_valid), .resp_status(resp_status),
    .resp_src(resp_src), .resp_offset(resp_offset), .resp_len(resp_len),
    .rd_start(rd_start), .rd_lba(rd_lba), .rd_count(rd_count), .rd_mode(rd_mode),
    .err_reg(err_reg), .sense_byte(sense_byte)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] pb(bit [95:0] p, int i);
    return p[8*i +: 8];
  endfunction

  // expected response per requirement, updates the model
  bit [7:0]  e_st;
  bit [15:0] e_len;
  bit [2:0]  e_src;
  bit [7:0]  e_ofs;
  bit        e_start;

  task automatic record(bit [15:0] r);
    m_sense[0] = 8'hF0;
    m_sense[2] = r[7:0];
    m_sense[8] = r[15:8];
    m_err      = {r[3:0], 4'h0};
    e_st  = (r == 0) ? 8'h50 : 8'h51;
    e_len = 0;
    e_src = 0;
  endtask

  task automatic expect_for(bit [95:0] p, bit disc, bit [15:0] mc);
    bit [7:0] op;
    int n;
    op = pb(p, 0);
    e_start = 0;
    e_ofs   = 0;
    if (m_was_reset && op != 8'h13) begin
      record(16'h2906);           // R3
      m_was_reset = 0;
    end else if (op == 8'h00 || op == 8'h20 || op == 8'h70) begin
      record(0);                  // R5
    end else if (op == 8'h11) begin
      if (pb(p, 2) >= 32) record(16'h2405);   // R6
      else begin
        record(0);
        n = 32 - pb(p, 2);
        e_len = (pb(p, 4) < n) ? 16'(pb(p, 4)) : 16'(n);
        e_st = 8'h58; e_src = 1; e_ofs = pb(p, 2);
      end
    end else if (op == 8'h13) begin           // R9
      e_st = 8'h58; e_src = 2; e_len = (pb(p, 4) > 10) ? 16'd10 : 16'(pb(p, 4));
    end else if (op == 8'h14) begin           // R7
      if (!disc) record(16'h3A02);
      else if (mc != 0) record(mc);
      else begin
        record(0);
        n = {pb(p, 3), pb(p, 4)};
        e_len = (n > 408) ? 16'd408 : 16'(n);
        e_st = 8'h58; e_src = 3;
      end
    end else if (op == 8'h30) begin           // R8
      if (!disc) record(16'h3A02);
      else if (mc != 0) begin
        record(mc);
        m_sense[5] = pb(p, 2); m_sense[6] = pb(p, 3); m_sense[7] = pb(p, 4);
      end else if ({pb(p, 8), pb(p, 9), pb(p, 10)} == 0) record(0);
      else begin
        record(0);
        e_st = 8'h58; e_src = 4; e_len = 2048; e_start = 1;
      end
    end else begin
      record(16'h2005);                       // R11
    end
  endtask

  task automatic check_sense(string req);
    for (int i = 0; i < 12; i++) begin
      sense_idx = 4'(i);
      #0.1;
      check(req, sense_byte, (i < 10) ? m_sense[i] : 8'h00);  // R12
    end
    check(req, err_reg, m_err);
  endtask

  task automatic send(bit [95:0] p, bit disc, bit [15:0] mc, string req, bit full = 0);
    @(negedge clk);
    pkt_data = p; disc_present = disc; media_code = mc; pkt_valid = 1;
    @(negedge clk);
    pkt_valid = 0;
    expect_for(p, disc, mc);
    check({req, " valid"}, resp_valid, 1);
    check({req, " status"}, resp_status, e_st);
    check({req, " src"}, resp_src, e_src);
    check({req, " len"}, resp_len, e_len);
    check({req, " start"}, rd_start, e_start);
    if (e_src == 1) check({req, " ofs"}, resp_offset, e_ofs);
    if (e_start) begin
      check({req, " lba"}, rd_lba, {pb(p, 2), pb(p, 3), pb(p, 4)});
      check({req, " cnt"}, rd_count, {pb(p, 8), pb(p, 9), pb(p, 10)});
      check({req, " mode"}, rd_mode, pb(p, 1));
    end
    if (full) check_sense({req, " sense"});
    else check({req, " err"}, err_reg, m_err);
    resp_ack = 1;
    @(negedge clk);
    resp_ack = 0;
    check("R2 released", resp_valid, 0);
  endtask

  function automatic bit [95:0] mkpkt(bit [7:0] op, bit [7:0] b1, bit [7:0] b2,
      bit [7:0] b3, bit [7:0] b4, bit [23:0] cnt);
    bit [95:0] p;
    p = '0;
    p[7:0] = op; p[15:8] = b1; p[23:16] = b2; p[31:24] = b3; p[39:32] = b4;
    p[71:64] = cnt[23:16]; p[79:72] = cnt[15:8]; p[87:80] = cnt[7:0];
    return p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit [7:0] ops [9];
    bit [15:0] st_hold;
    void'($urandom(32'h5EED));
    ops = '{8'h00, 8'h11, 8'h13, 8'h14, 8'h20, 8'h30, 8'h70, 8'h55, 8'hFF};
    rst_n = 0; pkt_valid = 0; pkt_data = '0; disc_present = 1;
    media_code = 0; resp_ack = 0; sense_idx = 0;
    m_was_reset = 1; m_err = 0;
    for (int i = 0; i < 10; i++) m_sense[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", resp_valid, 0);
    check("R1 start", rd_start, 0);
    check("R1 status", resp_status, 0);
    check_sense("R1 sense");

    // R3 / R9: sense does not clear the flag, next command is rejected
    send(mkpkt(8'h13, 0, 0, 0, 8'd20, 0), 1, 0, "R9 sense after reset", 1);
    send(mkpkt(8'h00, 0, 0, 0, 0, 0), 1, 0, "R3 reject", 1);
    send(mkpkt(8'h00, 0, 0, 0, 0, 0), 1, 0, "R5 ready", 1);
    send(mkpkt(8'h11, 0, 8'd31, 0, 8'd5, 0), 1, 0, "R6 clip", 1);
    send(mkpkt(8'h11, 0, 8'd32, 0, 8'd5, 0), 1, 0, "R6 badfield", 1);
    send(mkpkt(8'h13, 0, 0, 0, 8'd4, 0), 1, 0, "R9 keeps sense", 1);
    send(mkpkt(8'h14, 0, 0, 8'h04, 8'h00, 0), 1, 0, "R7 clip", 1);
    send(mkpkt(8'h14, 0, 0, 8'h00, 8'h10, 0), 1, 0, "R7 short", 1);
    send(mkpkt(8'h30, 8'h28, 8'h12, 8'h34, 8'h56, 24'd3), 0, 0, "R10 nodisc", 1);
    send(mkpkt(8'h30, 8'h28, 8'h12, 8'h34, 8'h56, 24'd3), 1, 16'h1103, "R8 media err", 1);
    send(mkpkt(8'h30, 8'h28, 8'h00, 8'h00, 8'h96, 24'h010203), 1, 0, "R8 start", 1);
    send(mkpkt(8'h30, 8'h20, 8'h00, 8'h00, 8'h96, 24'd0), 1, 0, "R8 count0", 1);
    send(mkpkt(8'h99, 0, 0, 0, 0, 0), 1, 0, "R11 badcmd", 1);

    // R2: strobe while pending is ignored
    @(negedge clk);
    pkt_data = mkpkt(8'h20, 0, 0, 0, 0, 0); pkt_valid = 1;
    @(negedge clk);
    pkt_valid = 0;
    record(0);
    st_hold = resp_status;
    pkt_data = mkpkt(8'h77, 0, 0, 0, 0, 0); pkt_valid = 1;
    @(negedge clk);
    pkt_valid = 0;
    check("R2 pending status", resp_status, st_hold);
    check_sense("R2 pending sense");
    resp_ack = 1;
    @(negedge clk);
    resp_ack = 0;
    repeat (2) @(negedge clk);
    check("R2 no late response", resp_valid, 0);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      bit [95:0] p;
      bit [15:0] mc;
      p = {$urandom(), $urandom(), $urandom()};
      p[7:0] = ops[$urandom_range(0, 8)];
      if ($urandom_range(0, 1) == 1) p[23:16] = 8'($urandom_range(0, 40));
      if ($urandom_range(0, 2) == 0) p[87:64] = 24'($urandom_range(0, 1));
      mc = ($urandom_range(0, 2) == 0) ? 16'($urandom_range(1, 65535)) : 16'h0;
      send(p, 1'($urandom_range(0, 3) != 0), mc, "R4 random", (n % 8) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule